// File: doc/BRIEF.md
# Row-Hit-First Memory Request Scheduler

This block keeps a short list of memory requests that are waiting to go to DRAM. Each request carries a bank number, a row and a column. In every cycle the block looks at all of the waiting requests and offers one of them on its issue port. It decides using the open-row state of each bank, which it receives as an input. A request whose row is already open in its bank is preferred. When several requests have the same standing, the one that arrived first goes first. If the oldest request has been passed over for too long, it is forced out ahead of the rest.

Entries are stored in arrival order in a compacting queue, so slot 0 always holds the oldest entry. The pick works in four named modes. MODE_IDLE applies when the queue is empty. MODE_STARVE applies when the oldest entry's wait has reached the cap. MODE_HIT applies when at least one entry hits its bank's open row. MODE_OLDEST applies when there is no hit. The mode is re-evaluated from the queue contents and the open-row inputs every cycle, with this priority:
- IDLE → STARVE when the oldest entry ages out.
- → HIT when a row hit appears.
- → OLDEST otherwise.

Top module: `rowhit_sched`

## Requirements
- R1: While and directly after synchronous active-low reset, the queue is empty, `iss_valid` is 0 and `enq_ready` is 1.
- R2: `iss_valid` is 1 exactly when at least one request is held.
- R3: When any held request hits its bank's open row and the oldest entry is not starved, the offered request is a hit and `iss_hit` is 1.
- R4: Among several hitting requests, the earliest-arrived one is offered.
- R5: When no held request hits, the earliest-arrived request is offered and `iss_hit` is 0.
- R6: A request hits only if `open_vld[bank]` is 1 and `open_row[bank*ROW_W +: ROW_W]` equals its row. A bank with no open row produces no hits.
- R7: `enq_ready` is 0 only when the queue holds DEPTH entries and no issue fires in that cycle. An enqueue and an issue in the same cycle are both accepted.
- R8: An issue (`iss_valid && iss_ready`) removes exactly the offered entry. All other entries keep their relative arrival order, and a new entry is placed behind all of them.
- R9: Each entry counts the clock edges it has waited, saturating at AGE_CAP. Once the oldest entry's count equals AGE_CAP (AGE_CAP > 0), it is offered regardless of hits. AGE_CAP = 0 disables this rule.
- R10: `iss_hit` reports whether the offered request hits, evaluated against the current open-row inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | New request present |
| enq_ready | output | 1 | Request can be taken this cycle |
| enq_bank | input | BANK_W | Bank of new request |
| enq_row | input | ROW_W | Row of new request |
| enq_col | input | COL_W | Column of new request |
| open_vld | input | NBANK | Per-bank open-row flag |
| open_row | input | NBANK*ROW_W | Per-bank open row, bank b at b*ROW_W |
| iss_valid | output | 1 | A request is offered |
| iss_ready | input | 1 | Consumer takes the offered request |
| iss_bank | output | BANK_W | Bank of offered request |
| iss_row | output | ROW_W | Row of offered request |
| iss_col | output | COL_W | Column of offered request |
| iss_hit | output | 1 | Offered request hits its bank's open row |

## Verification
The bench builds the block with DEPTH=4, NBANK=2, ROW_W=2 and AGE_CAP=6. The two-bit rows and two banks make row hits common, and the hit state often varies across entries. The shallow queue fills within a few cycles, so full-queue back-pressure and simultaneous enqueue and issue occur often. The short cap lets a directed stream of hits starve a missing oldest entry until it is forced out. A phase with no open rows checks plain arrival order.

// File: rtl/rowhit_sched_pkg.sv
package rowhit_sched_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_HIT,
        MODE_OLDEST,
        MODE_STARVE
    } pick_mode_e;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
    parameter int DEPTH   = 8,
    parameter int BANK_W  = 3,
    parameter int ROW_W   = 14,
    parameter int COL_W   = 10,
    parameter int AGE_CAP = 32,
    parameter int AGE_W   = 6,
    parameter int IDX_W   = 3,
    parameter int CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enq_fire,
    input  logic [BANK_W-1:0] enq_bank,
    input  logic [ROW_W-1:0]  enq_row,
    input  logic [COL_W-1:0]  enq_col,
    input  logic              deq_fire,
    input  logic [IDX_W-1:0]  deq_idx,
    output logic [DEPTH-1:0]  q_vld,
    output logic [BANK_W-1:0] q_bank [DEPTH],
    output logic [ROW_W-1:0]  q_row  [DEPTH],
    output logic [COL_W-1:0]  q_col  [DEPTH],
    output logic [AGE_W-1:0]  q_age  [DEPTH],
    output logic [CNT_W-1:0]  q_cnt
);
    logic [DEPTH-1:0]  vld_r, n_vld;
    logic [BANK_W-1:0] bank_r [DEPTH];
    logic [BANK_W-1:0] n_bank [DEPTH];
    logic [ROW_W-1:0]  row_r  [DEPTH];
    logic [ROW_W-1:0]  n_row  [DEPTH];
    logic [COL_W-1:0]  col_r  [DEPTH];
    logic [COL_W-1:0]  n_col  [DEPTH];
    logic [AGE_W-1:0]  age_r  [DEPTH];
    logic [AGE_W-1:0]  n_age  [DEPTH];
    logic [CNT_W-1:0]  cnt_after;

    // Compact out the issued slot, age the survivors, append the newcomer.
    always_comb begin
        cnt_after = '0;
        for (int i = 0; i < DEPTH; i++) begin
            int  src;
            logic take;
            src  = (i < DEPTH-1) ? i + 1 : i;
            take = deq_fire && (i >= int'(deq_idx));
            if (take) begin
                n_vld[i]  = (i < DEPTH-1) ? vld_r[src] : 1'b0;
                n_bank[i] = bank_r[src];
                n_row[i]  = row_r[src];
                n_col[i]  = col_r[src];
                n_age[i]  = age_r[src];
            end else begin
                n_vld[i]  = vld_r[i];
                n_bank[i] = bank_r[i];
                n_row[i]  = row_r[i];
                n_col[i]  = col_r[i];
                n_age[i]  = age_r[i];
            end
            if (n_vld[i] && (AGE_CAP > 0) && (int'(n_age[i]) < AGE_CAP))
                n_age[i] = n_age[i] + 1'b1;
            cnt_after = cnt_after + CNT_W'(n_vld[i]);
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (enq_fire && (int'(cnt_after) == i)) begin
                n_vld[i]  = 1'b1;
                n_bank[i] = enq_bank;
                n_row[i]  = enq_row;
                n_col[i]  = enq_col;
                n_age[i]  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_r <= '0;
        end else begin
            vld_r <= n_vld;
        end
        for (int i = 0; i < DEPTH; i++) begin
            bank_r[i] <= n_bank[i];
            row_r[i]  <= n_row[i];
            col_r[i]  <= n_col[i];
            age_r[i]  <= n_age[i];
        end
    end

    always_comb begin
        q_cnt = '0;
        for (int i = 0; i < DEPTH; i++) q_cnt = q_cnt + CNT_W'(vld_r[i]);
    end

    assign q_vld  = vld_r;
    assign q_bank = bank_r;
    assign q_row  = row_r;
    assign q_col  = col_r;
    assign q_age  = age_r;

    // R8: held entries always form a gap-free run from slot 0
    generate
        for (genvar g = 0; g < DEPTH-1; g++) begin : g_pack
            no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !vld_r[g] |-> !vld_r[g+1]);
        end
    endgenerate
endmodule

// File: rtl/sched_hit.sv
module sched_hit #(
    parameter int DEPTH  = 8,
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 14
) (
    input  logic [DEPTH-1:0]       q_vld,
    input  logic [BANK_W-1:0]      q_bank [DEPTH],
    input  logic [ROW_W-1:0]       q_row  [DEPTH],
    input  logic [NBANK-1:0]       open_vld,
    input  logic [NBANK*ROW_W-1:0] open_row,
    output logic [DEPTH-1:0]       hit
);
    logic [ROW_W-1:0] bank_row [NBANK];

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign bank_row[b] = open_row[b*ROW_W +: ROW_W];
        end
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_comb begin
                hit[s] = 1'b0;
                if (q_vld[s] && (int'(q_bank[s]) < NBANK))
                    hit[s] = open_vld[q_bank[s]] && (bank_row[q_bank[s]] == q_row[s]);
            end
        end
    endgenerate
endmodule

// File: rtl/sched_pick.sv
module sched_pick
    import rowhit_sched_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int AGE_CAP = 32,
    parameter int AGE_W   = 6,
    parameter int IDX_W   = 3
) (
    input  logic [DEPTH-1:0] q_vld,
    input  logic [DEPTH-1:0] hit,
    input  logic [AGE_W-1:0] age0,
    output pick_mode_e       mode,
    output logic [IDX_W-1:0] sel_idx
);
    logic             starve;
    logic [IDX_W-1:0] first_hit;

    generate
        if (AGE_CAP > 0) begin : g_cap
            assign starve = q_vld[0] && (int'(age0) >= AGE_CAP);
        end else begin : g_nocap
            assign starve = 1'b0;
        end
    endgenerate

    always_comb begin
        first_hit = '0;
        for (int i = DEPTH-1; i >= 0; i--)
            if (hit[i]) first_hit = IDX_W'(i);
    end

    always_comb begin
        if (!q_vld[0])   mode = MODE_IDLE;
        else if (starve) mode = MODE_STARVE;
        else if (|hit)   mode = MODE_HIT;
        else             mode = MODE_OLDEST;
    end

    always_comb begin
        unique case (mode)
            MODE_IDLE:   sel_idx = '0;
            MODE_STARVE: sel_idx = '0;
            MODE_HIT:    sel_idx = first_hit;
            MODE_OLDEST: sel_idx = '0;
            default:     sel_idx = '0;
        endcase
    end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
    import rowhit_sched_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int NBANK   = 8,
    parameter int ROW_W   = 14,
    parameter int COL_W   = 10,
    parameter int AGE_CAP = 32,
    parameter int BANK_W  = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enq_valid,
    output logic                   enq_ready,
    input  logic [BANK_W-1:0]      enq_bank,
    input  logic [ROW_W-1:0]       enq_row,
    input  logic [COL_W-1:0]       enq_col,
    input  logic [NBANK-1:0]       open_vld,
    input  logic [NBANK*ROW_W-1:0] open_row,
    output logic                   iss_valid,
    input  logic                   iss_ready,
    output logic [BANK_W-1:0]      iss_bank,
    output logic [ROW_W-1:0]       iss_row,
    output logic [COL_W-1:0]       iss_col,
    output logic                   iss_hit
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int AGE_W = (AGE_CAP > 0) ? $clog2(AGE_CAP+1) : 1;

    logic [DEPTH-1:0]  q_vld, hit;
    logic [BANK_W-1:0] q_bank [DEPTH];
    logic [ROW_W-1:0]  q_row  [DEPTH];
    logic [COL_W-1:0]  q_col  [DEPTH];
    logic [AGE_W-1:0]  q_age  [DEPTH];
    logic [CNT_W-1:0]  q_cnt;
    logic [IDX_W-1:0]  sel_idx;
    pick_mode_e        mode;
    logic              iss_fire, enq_fire;

    sched_queue #(
        .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W),
        .AGE_CAP(AGE_CAP), .AGE_W(AGE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_queue (
        .clk(clk), .rst_n(rst_n),
        .enq_fire(enq_fire), .enq_bank(enq_bank), .enq_row(enq_row), .enq_col(enq_col),
        .deq_fire(iss_fire), .deq_idx(sel_idx),
        .q_vld(q_vld), .q_bank(q_bank), .q_row(q_row), .q_col(q_col),
        .q_age(q_age), .q_cnt(q_cnt)
    );

    sched_hit #(
        .DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_hit (
        .q_vld(q_vld), .q_bank(q_bank), .q_row(q_row),
        .open_vld(open_vld), .open_row(open_row), .hit(hit)
    );

    sched_pick #(
        .DEPTH(DEPTH), .AGE_CAP(AGE_CAP), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_pick (
        .q_vld(q_vld), .hit(hit), .age0(q_age[0]), .mode(mode), .sel_idx(sel_idx)
    );

    always_comb begin
        unique case (mode)
            MODE_IDLE:   iss_valid = 1'b0;
            MODE_HIT,
            MODE_OLDEST,
            MODE_STARVE: iss_valid = 1'b1;
            default:     iss_valid = 1'b0;
        endcase
    end

    assign iss_fire  = iss_valid && iss_ready;
    assign enq_ready = (int'(q_cnt) < DEPTH) || iss_fire;
    assign enq_fire  = enq_valid && enq_ready;
    assign iss_bank  = q_bank[sel_idx];
    assign iss_row   = q_row[sel_idx];
    assign iss_col   = q_col[sel_idx];
    assign iss_hit   = hit[sel_idx];

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !iss_valid);
    // R2
    valid_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid == (q_cnt != '0));
    // R3
    hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && (|hit) && !(AGE_CAP > 0 && int'(q_age[0]) >= AGE_CAP)) |-> iss_hit);
    // R9
    starve_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && AGE_CAP > 0 && int'(q_age[0]) >= AGE_CAP) |-> (sel_idx == '0));
    // R7
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_fire && !iss_fire) |=> (q_cnt == $past(q_cnt) + 1'b1));
    // R8
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && !enq_fire) |=> (q_cnt == $past(q_cnt) - 1'b1));
endmodule

// File: tb/rowhit_sched_bench.sv
`timescale 1ns/1ps
module rowhit_sched_bench;
    localparam int DEPTH = 4, NBANK = 2, ROW_W = 2, COL_W = 8, AGE_CAP = 6;
    localparam int BANK_W = 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, enq_valid, enq_ready, iss_valid, iss_ready, iss_hit;
    logic [BANK_W-1:0]      enq_bank, iss_bank;
    logic [ROW_W-1:0]       enq_row, iss_row;
    logic [COL_W-1:0]       enq_col, iss_col;
    logic [NBANK-1:0]       open_vld;
    logic [NBANK*ROW_W-1:0] open_row;

    rowhit_sched #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .COL_W(COL_W),
                   .AGE_CAP(AGE_CAP)) u_rowhit_sched (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_bank(enq_bank), .enq_row(enq_row), .enq_col(enq_col),
        .open_vld(open_vld), .open_row(open_row), .iss_valid(iss_valid),
        .iss_ready(iss_ready), .iss_bank(iss_bank), .iss_row(iss_row),
        .iss_col(iss_col), .iss_hit(iss_hit));

    int mb[$], mr[$], mc[$], ma[$];
    int n_chk = 0, n_bad = 0, seq = 0;

    function automatic bit m_hit(int k);
        return open_vld[mb[k]] && (int'(open_row[mb[k]*ROW_W +: ROW_W]) == mr[k]);
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // One cycle: inputs already set after a falling edge.
    task automatic step();
        int sel, ev, fire, acc, starve, anyh;
        string tg;
        #2;
        ev = (mb.size() != 0);
        sel = 0; starve = 0; anyh = 0;
        if (ev) begin
            starve = (AGE_CAP > 0) && (ma[0] >= AGE_CAP);
            if (!starve)
                for (int k = mb.size()-1; k >= 0; k--)
                    if (m_hit(k)) begin sel = k; anyh = 1; end
        end
        fire = ev && iss_ready;
        check("R2 iss_valid", iss_valid, ev);
        check("R7 enq_ready", enq_ready, (mb.size() < DEPTH) || fire);
        if (ev) begin
            if (starve)          tg = "R9 forced oldest";
            else if (anyh)       tg = "R4 oldest hit";
            else if (open_vld == 0) tg = "R6 no open rows";
            else                 tg = "R5 oldest miss";
            check({tg, " bank"}, iss_bank, mb[sel]);
            check({tg, " row"}, iss_row, mr[sel]);
            check("R8 order col", iss_col, mc[sel]);
            check(anyh ? "R3 hit flag" : "R10 hit flag", iss_hit, m_hit(sel));
        end
        acc = enq_valid && ((mb.size() < DEPTH) || fire);
        @(posedge clk);
        if (fire) begin
            mb.delete(sel); mr.delete(sel); mc.delete(sel); ma.delete(sel);
        end
        foreach (ma[k]) if (AGE_CAP > 0 && ma[k] < AGE_CAP) ma[k]++;
        if (acc) begin
            mb.push_back(int'(enq_bank)); mr.push_back(int'(enq_row));
            mc.push_back(int'(enq_col)); ma.push_back(0);
        end
        @(negedge clk);
    endtask

    task automatic set_enq(bit v, int b, int r);
        enq_valid = v;
        enq_bank  = BANK_W'(b);
        enq_row   = ROW_W'(r);
        enq_col   = COL_W'(seq);
        seq++;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        rst_n = 1'b0; iss_ready = 1'b0; open_vld = '0; open_row = '0;
        set_enq(0, 0, 0);
        repeat (3) @(negedge clk);
        check("R1 reset iss_valid", iss_valid, 0);
        check("R1 reset enq_ready", enq_ready, 1);
        rst_n = 1'b1;

        // R3 R4 R5 R10: mixed random traffic
        for (int c = 0; c < 1500; c++) begin
            set_enq($urandom_range(0, 2) != 0, $urandom_range(0, 1), $urandom_range(0, 3));
            iss_ready = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 3) == 0) begin
                open_vld = NBANK'($urandom);
                open_row = (NBANK*ROW_W)'($urandom);
            end
            step();
        end

        // R7: fill to full, then enqueue and issue together
        iss_ready = 1'b0;
        for (int c = 0; c < 6; c++) begin set_enq(1, c % 2, c % 4); step(); end
        iss_ready = 1'b1;
        for (int c = 0; c < 8; c++) begin set_enq(1, c % 2, (c+1) % 4); step(); end

        // R6: no open rows, pure arrival order
        open_vld = '0;
        for (int c = 0; c < 200; c++) begin
            set_enq($urandom_range(0, 1) == 1, $urandom_range(0, 1), $urandom_range(0, 3));
            iss_ready = ($urandom_range(0, 2) == 0);
            step();
        end

        // R9: miss at the head, stream of hits behind it
        set_enq(0, 0, 0); iss_ready = 1'b1;
        while (mb.size() != 0) step();
        open_vld = 2'b11; open_row = {2'd1, 2'd1};
        iss_ready = 1'b0;
        set_enq(1, 0, 2); step();
        iss_ready = 1'b1;
        for (int c = 0; c < 20; c++) begin set_enq(1, 1, 1); step(); end

        // R8: random with many simultaneous enqueue and issue
        for (int c = 0; c < 1000; c++) begin
            set_enq($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 3));
            iss_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 7) == 0) begin
                open_vld = NBANK'($urandom);
                open_row = (NBANK*ROW_W)'($urandom);
            end
            step();
        end
        summary();
    end
endmodule